// File: doc/BRIEF.md
# Signed Word Divider with Overflow and Condition Flags

This block is the divide unit of a 32-bit processor execution stage. It takes two signed 32-bit operands and produces their quotient rounded toward zero, so the implied remainder always carries the dividend's sign and is smaller in magnitude than the divisor. It spends one clock per quotient bit on the operand magnitudes and fixes the sign at the end.

Two divisions have no valid result: any value divided by zero, and the most negative word (0x80000000) divided by minus one. The block detects both when the operation is accepted and answers on the next cycle without iterating. It returns a defined quotient of zero. When overflow recording is enabled, it raises an overflow flag and folds it into a sticky summary bit that it never clears. When condition recording is enabled, it also returns a 4-bit sign/zero field for the quotient.

Control is a start/busy/done handshake. The operands, both enable bits and the incoming sticky bit are captured on the accepting edge. The results stay on the outputs until the next operation completes.

Top module: `sdiv_flags_unit`

## Requirements
- R1: After reset, busy, done, ovf, so_out, quotient and cond are all 0.
- R2: For a valid division, quotient is the signed quotient truncated toward zero, so that dividend = quotient × divisor + r with r zero or of the dividend's sign and |r| < |divisor|.
- R3: A divisor of 0 is an invalid division for any dividend, and the quotient returned is 0.
- R4: Dividend 0x80000000 with divisor 0xFFFFFFFF is an invalid division, and the quotient returned is 0.
- R5: When ovf_en was 1 at acceptance, ovf is 1 exactly for an invalid division, and so_out is so_in OR ovf.
- R6: When ovf_en was 0 at acceptance, ovf is 0 and so_out equals the so_in captured at acceptance.
- R7: When cond_en was 1, cond[3] is quotient < 0, cond[2] is quotient > 0 and cond[1] is quotient == 0; on an invalid division these three bits are 0. In both cases cond[0] equals so_out. When cond_en was 0, cond is 0.
- R8: done is a single-cycle pulse. It comes 33 rising edges after the accepting edge for a valid division and 1 edge after it for an invalid one. busy is high from the accepting edge until the cycle in which done is high, and is low in that cycle.
- R9: start is ignored while busy is high. Operand, enable and so_in inputs that change after the accepting edge have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a division; accepted when busy is low |
| dividend | input | 32 | Signed dividend |
| divisor | input | 32 | Signed divisor |
| ovf_en | input | 1 | Record overflow into ovf and so_out |
| cond_en | input | 1 | Produce the condition field |
| so_in | input | 1 | Incoming sticky summary-overflow bit |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | 32 | Signed quotient (0 on invalid division) |
| ovf | output | 1 | Overflow flag |
| so_out | output | 1 | Outgoing sticky summary-overflow bit |
| cond | output | 4 | {less, greater, equal, summary overflow} |

## Verification
The bench counts rising edges from the accepting edge. It requires done to be low at every earlier sample and high at sample 33 for a valid division, or at sample 1 for an invalid one. Quotient, flags and condition field are compared in that same done cycle, at the falling edge. busy is checked high at the first sample after acceptance and low at the done sample, and done is checked low again one cycle later. In the ignored-start case, a second start and new operand values are driven mid-run, and the check confirms that the first operation's result still arrives at edge 33.

// File: rtl/sdiv_pkg.sv
// Package: shared widths and types of the signed divider.
// Assumes a two's-complement word of DATA_W bits.
package sdiv_pkg;
    parameter int DATA_W = 32;
    parameter int COND_W = 4;

    // Sequencer states of the divider.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } sdiv_state_e;

    // Condition field layout, most significant bit first.
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } sdiv_cond_t;
endpackage

// File: rtl/sdiv_operand_prep.sv
// Module: sdiv_operand_prep
// Turns two signed operands into unsigned magnitudes, a result-sign bit and
// an invalid-division flag (zero divisor, or most-negative over minus one).
// Purely combinational; assumes W >= 2.
module sdiv_operand_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] dvd_mag,
    output logic [W-1:0] dvs_mag,
    output logic         neg_res,
    output logic         invalid
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MINUS_1  = {W{1'b1}};

    // Magnitude and sign extraction for both operands.
    always_comb begin
        dvd_mag = dvd[W-1] ? (~dvd + 1'b1) : dvd;
        dvs_mag = dvs[W-1] ? (~dvs + 1'b1) : dvs;
        neg_res = dvd[W-1] ^ dvs[W-1];
    end

    // Detection of the two divisions with no defined result.
    always_comb begin
        invalid = (dvs == '0) || ((dvd == MOST_NEG) && (dvs == MINUS_1));
    end
endmodule

// File: rtl/sdiv_core.sv
// Module: sdiv_core
// Unsigned restoring shift-subtract divider, one quotient bit per step.
// load seeds the dividend magnitude; each step shifts one bit into the
// partial remainder and keeps the subtraction when it does not go negative.
// After W steps quo_mag holds the quotient and rem_mag the remainder.
// Assumes dvs_mag is held stable across the steps and is nonzero.
module sdiv_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dvd_mag,
    input  logic [W-1:0] dvs_mag,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag
);
    logic [W-1:0] rem_q, quo_q;
    logic [W:0]   shifted;
    logic [W:0]   trial;

    // Trial subtraction for the current step.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, dvs_mag};
    end

    // Partial remainder and quotient shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            quo_q <= dvd_mag;
        end else if (step) begin
            if (!trial[W]) begin
                rem_q <= trial[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    assign quo_mag = quo_q;
    assign rem_mag = rem_q;
endmodule

// File: rtl/sdiv_result_fmt.sv
// Module: sdiv_result_fmt
// Applies the result sign, forces zero on invalid divisions and builds the
// overflow, sticky-summary and condition outputs from the enable bits.
// Purely combinational; the caller registers the outputs.
module sdiv_result_fmt
    import sdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] quo_mag,
    input  logic         neg_res,
    input  logic         invalid,
    input  logic         ovf_en,
    input  logic         cond_en,
    input  logic         so_in,
    output logic [W-1:0] quotient,
    output logic         ovf,
    output logic         so_out,
    output sdiv_cond_t   cond
);
    // Signed quotient, zero for an invalid division.
    always_comb begin
        if (invalid)      quotient = '0;
        else if (neg_res) quotient = ~quo_mag + 1'b1;
        else              quotient = quo_mag;
    end

    // Overflow flag and sticky summary bit.
    always_comb begin
        ovf    = ovf_en & invalid;
        so_out = so_in | ovf;
    end

    // Condition field on the signed quotient.
    always_comb begin
        cond = '0;
        if (cond_en) begin
            cond.lt = !invalid && quotient[W-1];
            cond.gt = !invalid && !quotient[W-1] && (quotient != '0);
            cond.eq = !invalid && (quotient == '0);
            cond.so = so_out;
        end
    end
endmodule

// File: rtl/sdiv_flags_unit.sv
// Module: sdiv_flags_unit (top)
// Multi-cycle signed divider with overflow and condition flags. Accepts an
// operation on start while idle, captures all inputs, iterates DATA_W steps
// (or none for an invalid division) and presents registered results with a
// one-cycle done pulse. Results hold until the next completion.
module sdiv_flags_unit
    import sdiv_pkg::*;
#(
    parameter int W = sdiv_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         ovf_en,
    input  logic         cond_en,
    input  logic         so_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic         ovf,
    output logic         so_out,
    output logic [3:0]   cond
);
    localparam int            CW   = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sdiv_state_e   state_q;
    logic [CW-1:0] cnt_q;

    logic [W-1:0]  dvd_mag_c, dvs_mag_c;
    logic          neg_c, inv_c;

    logic [W-1:0]  dvd_mag_q, dvs_mag_q;
    logic          neg_q, inv_q, ovf_en_q, cond_en_q, so_in_q;

    logic          accept, core_load, core_step;
    logic [W-1:0]  quo_mag, rem_mag;

    logic [W-1:0]  quot_c;
    logic          ovf_c, so_c;
    sdiv_cond_t    cond_c;

    logic [W-1:0]  quot_q;
    logic          ovf_q, so_q, done_q;
    sdiv_cond_t    cond_q;

    assign accept    = start && (state_q == ST_IDLE);
    assign core_load = accept;
    assign core_step = (state_q == ST_RUN);

    sdiv_operand_prep #(.W(W)) u_prep (
        .dvd     (dividend),
        .dvs     (divisor),
        .dvd_mag (dvd_mag_c),
        .dvs_mag (dvs_mag_c),
        .neg_res (neg_c),
        .invalid (inv_c)
    );

    sdiv_core #(.W(W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (core_load),
        .step    (core_step),
        .dvd_mag (dvd_mag_c),
        .dvs_mag (dvs_mag_q),
        .quo_mag (quo_mag),
        .rem_mag (rem_mag)
    );

    sdiv_result_fmt #(.W(W)) u_fmt (
        .quo_mag  (quo_mag),
        .neg_res  (neg_q),
        .invalid  (inv_q),
        .ovf_en   (ovf_en_q),
        .cond_en  (cond_en_q),
        .so_in    (so_in_q),
        .quotient (quot_c),
        .ovf      (ovf_c),
        .so_out   (so_c),
        .cond     (cond_c)
    );

    // Capture of operands, enables and sticky bit on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_mag_q <= '0;
            dvs_mag_q <= '0;
            neg_q     <= 1'b0;
            inv_q     <= 1'b0;
            ovf_en_q  <= 1'b0;
            cond_en_q <= 1'b0;
            so_in_q   <= 1'b0;
        end else if (accept) begin
            dvd_mag_q <= dvd_mag_c;
            dvs_mag_q <= dvs_mag_c;
            neg_q     <= neg_c;
            inv_q     <= inv_c;
            ovf_en_q  <= ovf_en;
            cond_en_q <= cond_en;
            so_in_q   <= so_in;
        end
    end

    // Sequencer: idle, iterate, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    cnt_q   <= '0;
                    state_q <= inv_c ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIN;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result registers and done pulse, loaded when finishing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quot_q <= '0;
            ovf_q  <= 1'b0;
            so_q   <= 1'b0;
            cond_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_FIN) begin
                quot_q <= quot_c;
                ovf_q  <= ovf_c;
                so_q   <= so_c;
                cond_q <= cond_c;
                done_q <= 1'b1;
            end
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = done_q;
    assign quotient = quot_q;
    assign ovf      = ovf_q;
    assign so_out   = so_q;
    assign cond     = cond_q;

    // R8: done lasts one cycle and is never seen together with busy.
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: captured operands do not move while an operation runs.
    assert_hold_ops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(dvs_mag_q) && $stable(inv_q) && $stable(ovf_en_q));
    // R2: the finished magnitude remainder is below the divisor magnitude.
    assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN && !inv_q) |-> (rem_mag < dvs_mag_q));
    // R3 / R4: an invalid division always returns a zero quotient.
    assert_invalid_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN && inv_q) |=> (quotient == '0));
    // R5: the sticky summary is set whenever overflow is reported.
    assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> so_out);
    // R7: at most one of less / greater / equal is set.
    assert_cond_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cond[3:1]));
    // R7: the summary bit of the field mirrors so_out when present.
    assert_cond_so_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cond[3:1] != 3'b000) |-> (cond[0] == so_out));
endmodule

// File: tb/tb_sdiv_flags_unit.sv
`timescale 1ns/1ps
module tb_sdiv_flags_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] dividend = '0, divisor = '0;
    logic        ovf_en = 1'b0, cond_en = 1'b0, so_in = 1'b0;
    logic        busy, done, ovf, so_out;
    logic [31:0] quotient;
    logic [3:0]  cond;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sdiv_flags_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .ovf_en(ovf_en), .cond_en(cond_en), .so_in(so_in),
        .busy(busy), .done(done), .quotient(quotient),
        .ovf(ovf), .so_out(so_out), .cond(cond)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit is_invalid(input logic [31:0] a, input logic [31:0] b);
        return (b == 32'd0) || (a == 32'h8000_0000 && b == 32'hFFFF_FFFF);
    endfunction

    function automatic logic [31:0] exp_quot(input logic [31:0] a, input logic [31:0] b);
        if (is_invalid(a, b)) return 32'd0;
        return $signed(a) / $signed(b);
    endfunction

    // Runs one division; when intrude is set, a second start with other
    // inputs is driven mid-run. Checks latency, handshake and all results.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input bit oe, input bit ce, input bit si, input bit intrude);
        logic [31:0] q;
        bit inv, e_ovf, e_so;
        logic [3:0] e_cond;
        int lat, n;
        inv   = is_invalid(a, b);
        q     = exp_quot(a, b);
        e_ovf = oe && inv;
        e_so  = si || e_ovf;
        e_cond = 4'b0;
        if (ce) e_cond = {!inv && q[31], !inv && !q[31] && q != 0, !inv && q == 0, e_so};
        lat = inv ? 1 : 33;

        @(negedge clk);
        dividend = a; divisor = b; ovf_en = oe; cond_en = ce; so_in = si; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        dividend = ~a; divisor = 32'd3; ovf_en = !oe; cond_en = !ce; so_in = !si;
        check("R8", "busy after accept", {31'd0, busy}, 32'd1);
        n = 0;
        while (!done && n < 100) begin
            if (intrude && n == 4) begin
                start = 1'b1; dividend = 32'h8000_0000; divisor = 32'd0;
            end else begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        if (n >= 100) begin
            n_checks++; n_fails++;
            $display("FAIL R8 watchdog: actual no done expected done");
            return;
        end
        check("R8", "done latency", n, lat);
        check("R8", "busy low at done", {31'd0, busy}, 32'd0);
        check(intrude ? "R9" : (inv ? (b == 0 ? "R3" : "R4") : "R2"), "quotient", quotient, q);
        check(oe ? "R5" : "R6", "ovf", {31'd0, ovf}, {31'd0, e_ovf});
        check(oe ? "R5" : "R6", "so_out", {31'd0, so_out}, {31'd0, e_so});
        check("R7", "cond", {28'd0, cond}, {28'd0, e_cond});
        @(negedge clk);
        check("R8", "done single pulse", {31'd0, done}, 32'd0);
        check("R9", "no second op from ignored start", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "busy", {31'd0, busy}, 32'd0);
        check("R1", "done", {31'd0, done}, 32'd0);
        check("R1", "quotient", quotient, 32'd0);
        check("R1", "ovf/so", {30'd0, ovf, so_out}, 32'd0);
        check("R1", "cond", {28'd0, cond}, 32'd0);

        // Directed corners
        run_op(32'd7, 32'd2, 1, 1, 0, 0);                         // R2
        run_op(-32'sd7, 32'd2, 1, 1, 0, 0);                       // R2 trunc
        run_op(32'd7, -32'sd2, 0, 1, 1, 0);                       // R2, R6
        run_op(-32'sd7, -32'sd2, 1, 1, 1, 0);                     // R2, R5
        run_op(32'd1, 32'd5, 1, 1, 0, 0);                         // R7 eq
        run_op(32'h8000_0000, 32'd1, 1, 1, 0, 0);                 // R2 most neg
        run_op(32'h8000_0000, 32'd2, 0, 0, 0, 0);                 // R7 disabled
        run_op(32'h7FFF_FFFF, 32'h8000_0000, 1, 1, 0, 0);
        run_op(32'd123, 32'd0, 1, 1, 0, 0);                       // R3
        run_op(32'd0, 32'd0, 0, 1, 0, 0);                         // R3, R6
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1, 1, 0, 0);         // R4, R5
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1, 0);         // R4, R6
        run_op(32'd1000, 32'd7, 1, 1, 0, 1);                      // R9 ignored start
        run_op(-32'sd99, 32'd10, 0, 1, 0, 1);                     // R9

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            int sel;
            a = $urandom();
            b = $urandom();
            sel = $urandom_range(0, 9);
            if (sel == 0) b = 32'd0;
            else if (sel == 1) begin a = 32'h8000_0000; b = 32'hFFFF_FFFF; end
            else if (sel < 5) b = $urandom_range(1, 300) * (($urandom() & 1) ? 1 : -1);
            run_op(a, b, 1'($urandom()), 1'($urandom()), 1'($urandom()), 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule